// File: doc/BRIEF.md
# Four-Port Bidirectional Parallel I/O with Selectable Page Decode

This block gives a processor four byte-wide general-purpose ports in its 16-bit I/O address space. Every port owns a direction register, where each bit picks input or output for one pin, and a data register. A write to the data register stores the byte in an output latch. The latch is driven onto the pins whose direction bit selects output. A read of the data register does not return the latch. It returns the levels sampled on the external pins, after each pin has passed through a two-stage synchronizer.

A static configuration input selects how much of the address is decoded. With `pg_any` high, only the low address byte is compared, so the eight registers repeat in every 256-byte page. With `pg_any` low, an access also needs the upper address byte to be zero. The register window starts at `BASE` (default 0xE0). Port p has its direction register at `BASE+2p` and its data register at `BASE+2p+1`.

Top module: `pio_quad_port`

## Requirements
- R1: After reset every direction bit, every output-enable and every output latch bit is 0, so all pins are inputs.
- R2: A write to address BASE+2p (direction of port p) sets `pin_oe[8p+7:8p]` to the written byte from the next cycle onward. A read of that address returns the byte.
- R3: A write to address BASE+2p+1 (data of port p) sets `pin_out[8p+7:8p]` to the written byte. A pin is driven only where its `pin_oe` bit is 1, so the driven value is the latch ANDed with the direction.
- R4: A read of BASE+2p+1 returns `pin_in[8p+7:8p]` as it stood two clock edges earlier. After a pin change, a read following one edge still shows the old level, and a read following two edges shows the new level. The latch content is never returned.
- R5: With `pg_any`=1, the registers respond at any value of address bits 15:8.
- R6: With `pg_any`=0, an access whose address bits 15:8 are nonzero is ignored. A write changes no register, and a read returns 0.
- R7: Low address bytes outside BASE..BASE+7 select nothing. Writes there are ignored, and reads return 0. `io_rdata` is also 0 whenever `io_rd` is low.
- R8: When a read and a write to the same register fall in one cycle, the read returns the contents before the write, and the write takes effect for the next cycle.
- R9: A write to one port leaves the registers of the other three ports unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pg_any | input | 1 | 1: decode low address byte only; 0: upper byte must be zero |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational during `io_rd` |
| pin_in | input | 32 | External pin levels, port p at bits 8p+7:8p |
| pin_out | output | 32 | Output latches, port p at bits 8p+7:8p |
| pin_oe | output | 32 | Per-pin output enable (1 = drive) |

## Verification
A register write and a read of the same register can land in one bus cycle. The bench provokes this by raising `io_rd` and `io_wr` together on the port D direction register, with a new value on `io_wdata`. The returned byte must equal the old contents, and a separate read one cycle later must show the new byte. A second overlap is checked apart from this one: a change on the pins and a data read close behind it. Here the bench counts the edges and expects the old level after one edge and the new level after two.

// File: rtl/pio_quad_port.sv
module pio_quad_port #(
  parameter int          NPORT = 4,
  parameter int          W     = 8,
  parameter int          AW    = 16,
  parameter logic [7:0]  BASE  = 8'hE0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pg_any,
  input  logic [AW-1:0]       io_addr,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic [W-1:0]        io_wdata,
  output logic [W-1:0]        io_rdata,
  input  logic [NPORT*W-1:0]  pin_in,
  output logic [NPORT*W-1:0]  pin_out,
  output logic [NPORT*W-1:0]  pin_oe
);
  localparam int PW   = $clog2(NPORT);
  localparam int NREG = 2 * NPORT;

  logic [7:0]    off;
  logic          page_ok, hit, is_dat;
  logic [PW-1:0] psel;
  logic [W-1:0]  dir_q [NPORT];
  logic [W-1:0]  lat_q [NPORT];
  logic [W-1:0]  s1_q  [NPORT];
  logic [W-1:0]  s2_q  [NPORT];

  assign off     = io_addr[7:0] - BASE;
  assign page_ok = pg_any || (io_addr[AW-1:8] == '0);
  assign hit     = page_ok && (io_addr[7:0] >= BASE) && (int'(off) < NREG);
  assign psel    = off[PW:1];
  assign is_dat  = off[0];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_q[p] <= '0;
        lat_q[p] <= '0;
        s1_q[p]  <= '0;
        s2_q[p]  <= '0;
      end else begin
        s1_q[p] <= pin_in[p*W +: W];
        s2_q[p] <= s1_q[p];
        if (io_wr && hit && psel == PW'(p)) begin
          if (is_dat) lat_q[p] <= io_wdata;
          else        dir_q[p] <= io_wdata;
        end
      end
    end
    assign pin_out[p*W +: W] = lat_q[p];
    assign pin_oe[p*W +: W]  = dir_q[p];
  end

  always_comb begin
    io_rdata = '0;
    if (io_rd && hit) io_rdata = is_dat ? s2_q[psel] : dir_q[psel];
  end

  logic [1:0]           chk_age;
  logic [NPORT*W-1:0]   pin_d1, pin_d2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_age <= '0;
      pin_d1  <= '0;
      pin_d2  <= '0;
    end else begin
      if (chk_age != 2'd3) chk_age <= chk_age + 2'd1;
      pin_d1 <= pin_in;
      pin_d2 <= pin_d1;
    end
  end

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && hit && !is_dat) |=> pin_oe[$past(psel)*W +: W] == $past(io_wdata));

  p_dat_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && hit && is_dat) |=> pin_out[$past(psel)*W +: W] == $past(io_wdata));

  p_read_pins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_age >= 2'd2 && io_rd && hit && is_dat) |-> io_rdata == pin_d2[psel*W +: W]);

  p_no_stray_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && hit) |=> ($stable(pin_oe) && $stable(pin_out)));

  p_rd_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && hit) |-> io_rdata == '0);
endmodule

// File: tb/test_pio_quad_port.sv
module test_pio_quad_port;
  logic        clk = 0, rst_n = 0, pg_any = 0, io_wr = 0, io_rd = 0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0, io_rdata;
  logic [31:0] pin_in = '0, pin_out, pin_oe;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pio_quad_port i_pio_quad_port (
    .clk(clk), .rst_n(rst_n), .pg_any(pg_any), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(posedge clk); #1 io_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1;
    #1 d = io_rdata;
    #1 io_rd = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 oe", pin_oe, 32'h0);
    check("R1 out", pin_out, 32'h0);
    for (int p = 0; p < 4; p++) begin
      rd(16'h00E0 + 16'(2*p), d);
      check("R1 dir readback", {24'h0, d}, 32'h0);
    end
  endtask

  task automatic t_dir;
    logic [7:0] d;
    wr(16'h00E2, 8'hA5);
    check("R2 oe port B", pin_oe, 32'h0000A500);
    rd(16'h00E2, d);
    check("R2 dir readback", {24'h0, d}, 32'hA5);
    wr(16'h00E6, 8'h0F);
    check("R9 ports B and D", pin_oe, 32'h0F00A500);
  endtask

  task automatic t_data;
    wr(16'h00E3, 8'h3C);
    check("R3 latch port B", pin_out, 32'h00003C00);
    check("R3 driven bits", pin_out & pin_oe, 32'h00002400);
    wr(16'h00E1, 8'h81);
    check("R9 latch ports A and B", pin_out, 32'h00003C81);
  endtask

  task automatic t_pins;
    logic [7:0] d;
    @(negedge clk); pin_in = 32'h12345678;
    rd(16'h00E5, d);
    check("R4 one edge old", {24'h0, d}, 32'h00);
    rd(16'h00E5, d);
    check("R4 two edges new", {24'h0, d}, 32'h34);
    rd(16'h00E3, d);
    check("R4 pins not latch", {24'h0, d}, 32'h56);
  endtask

  task automatic t_page;
    logic [7:0] d;
    pg_any = 1;
    wr(16'h37E0, 8'hFF);
    check("R5 write any page", pin_oe, 32'h0F00A5FF);
    rd(16'h55E0, d);
    check("R5 read any page", {24'h0, d}, 32'hFF);
    pg_any = 0;
    wr(16'h12E2, 8'h00);
    check("R6 write upper page ignored", pin_oe, 32'h0F00A5FF);
    rd(16'h12E0, d);
    check("R6 read upper page zero", {24'h0, d}, 32'h00);
    rd(16'h00E0, d);
    check("R6 page zero works", {24'h0, d}, 32'hFF);
  endtask

  task automatic t_range;
    logic [7:0] d;
    wr(16'h00E8, 8'h77);
    wr(16'h00DF, 8'h77);
    check("R7 out-of-window oe", pin_oe, 32'h0F00A5FF);
    check("R7 out-of-window out", pin_out, 32'h00003C81);
    rd(16'h00E8, d);
    check("R7 read past window", {24'h0, d}, 32'h00);
    #1 check("R7 idle rdata", {24'h0, io_rdata}, 32'h00);
  endtask

  task automatic t_same;
    logic [7:0] d;
    @(negedge clk); io_addr = 16'h00E6; io_wdata = 8'hC3; io_wr = 1; io_rd = 1;
    #1 check("R8 read sees old", {24'h0, io_rdata}, 32'h0F);
    @(posedge clk); #1 io_wr = 0; io_rd = 0;
    rd(16'h00E6, d);
    check("R8 write landed", {24'h0, d}, 32'hC3);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_dir;
    t_data;
    t_pins;
    t_page;
    t_range;
    t_same;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule